// File: doc/BRIEF.md
# Push-Pull Pulse-Width Modulator with Dead-Time Steering

This block produces the two alternating gate-drive signals of a push-pull power converter from two digital control words. A free-running ramp counter takes the place of a sawtooth oscillator and restarts every `PERIOD` clock cycles. Within each ramp period the block opens a drive window only while the ramp value lies above both the error word and the dead-time word, the latter raised by a fixed built-in offset. Whichever word demands the shorter on-time sets the width, and raising either word shortens the pulse by one cycle per unit, down to nothing.

A steering flip-flop flips at every ramp restart and hands successive windows to output A and output B in turn. Each output therefore runs at half the ramp rate, and the built-in offset keeps its duty a little below 50 percent even with both words at zero. Both words are captured only on the cycle the ramp sits at zero, so a word change never splits a pulse. An inhibit line shuts both drives off in the same cycle and parks the steering on output A. The control words and the inhibit line are plain level inputs with no handshake. The block presents a one-cycle strobe at every ramp restart.

Top module: `pushpull_pwm`

## Requirements
- R1: The ramp counts 0 up to PERIOD-1 and then wraps to 0. `period_start` is high exactly in the cycles where the ramp is 0, so it pulses once every PERIOD cycles.
- R2: In a period where the captured words are e and d, the routed drive is high in the cycles where the ramp value v satisfies v > e and v > d + DT_OFS. The pulse width is therefore max(0, PERIOD-1-max(e, d+DT_OFS)) cycles.
- R3: The larger threshold of e and d + DT_OFS alone sets the width. Changing the other word while it stays the smaller one leaves the width unchanged.
- R4: Raising either governing word by k units shortens the pulse by exactly k cycles.
- R5: Both drives are low in every cycle where `period_start` is high, and `drv_a` and `drv_b` are never high together.
- R6: The steering flips at each ramp wrap. After reset or after inhibit is released, the first period drives `drv_a` and the next period drives `drv_b`.
- R7: With both words at zero the pulse width is PERIOD-1-DT_OFS. With the defaults this is 162 of 338 cycles per output, about 48 percent, which lies between 45 and 50 percent.
- R8: A dead-time word of PERIOD-1-DT_OFS or more, or an error word of PERIOD-1 or more, gives zero pulse width.
- R9: While `inhibit` is high, both drives are low in that same cycle and the steering is held at output A.
- R10: The words are captured only in the cycle where the ramp is 0. A change made later in a period first takes effect in the following period.
- R11: During and after reset, the ramp is at 0, both drives are low and the steering points to output A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_lvl | input | WORD_W | Error control word, in ramp counts |
| dt_lvl | input | WORD_W | Dead-time control word, in ramp counts |
| inhibit | input | 1 | Forces both drives off and parks the steering on A |
| drv_a | output | 1 | Drive for push-pull channel A |
| drv_b | output | 1 | Drive for push-pull channel B |
| period_start | output | 1 | High in the cycle where the ramp is at 0 |

## Verification
The hardest case to reach from the ports is a control word changing part-way through a period. The result must show the old width for the rest of that period and the new width only after the next restart. The bench aligns itself on `period_start`, writes the new error word on a chosen ramp count in the middle of a measured period, and then measures the following period as well. A second hard case is releasing inhibit on a restart cycle, where a release one cycle off would let the wrap flip the steering. The bench holds inhibit across several periods and drops it exactly on a `period_start` cycle. It then measures from that cycle and checks that the first pulse goes to A.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {
    PH_A = 1'b0,
    PH_B = 1'b1
  } steer_phase_e;
endpackage

// File: rtl/pwm_ramp.sv
module pwm_ramp #(
  parameter int PERIOD = 169,
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] ramp,
  output logic             at_start,
  output logic             at_end
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  always_ff @(posedge clk) begin
    if (rst)          ramp <= '0;
    else if (at_end)  ramp <= '0;
    else              ramp <= ramp + 1'b1;
  end

  assign at_start = (ramp == '0);
  assign at_end   = (ramp == LAST);

  // R1
  ramp_range_chk: assert property (@(posedge clk) disable iff (rst)
    ramp <= LAST);
  // R1
  ramp_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    at_end |=> at_start);
  // R1
  ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
    !at_end |=> ramp == $past(ramp) + 1'b1);
endmodule

// File: rtl/pwm_word_latch.sv
module pwm_word_latch #(
  parameter int WORD_W = 8,
  parameter int NUM    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [WORD_W-1:0] din  [NUM],
  output logic [WORD_W-1:0] dout [NUM]
);
  for (genvar g = 0; g < NUM; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)          dout[g] <= '1;
      else if (capture) dout[g] <= din[g];
    end

    // R10
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !capture |=> $stable(dout[g]));
  end
endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
  import pwm_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 8,
  parameter int DT_OFS = 6,
  localparam int CMP_W = ((CNT_W > WORD_W) ? CNT_W : WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  ramp,
  input  logic              at_end,
  input  logic              inhibit,
  input  logic [WORD_W-1:0] err_q,
  input  logic [WORD_W-1:0] dt_q,
  output logic              drv_a,
  output logic              drv_b
);
  steer_phase_e phase;
  logic [CMP_W-1:0] ramp_x, err_x, dt_x, thr;
  logic window;

  assign ramp_x = CMP_W'(ramp);
  assign err_x  = CMP_W'(err_q);
  assign dt_x   = CMP_W'(dt_q) + CMP_W'(DT_OFS);
  assign thr    = (err_x > dt_x) ? err_x : dt_x;
  assign window = (ramp_x > thr);

  always_ff @(posedge clk) begin
    if (rst || inhibit) phase <= PH_A;
    else if (at_end)    phase <= (phase == PH_A) ? PH_B : PH_A;
  end

  assign drv_a = window && !inhibit && (phase == PH_A);
  assign drv_b = window && !inhibit && (phase == PH_B);

  // R6
  steer_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (at_end && !inhibit) |=> phase != $past(phase));
  // R9
  steer_park_chk: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> phase == PH_A);
  // R6
  steer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!at_end && !inhibit) |=> $stable(phase));
endmodule

// File: rtl/pushpull_pwm.sv
module pushpull_pwm #(
  parameter int WORD_W = 8,
  parameter int PERIOD = 169,
  parameter int DT_OFS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] err_lvl,
  input  logic [WORD_W-1:0] dt_lvl,
  input  logic              inhibit,
  output logic              drv_a,
  output logic              drv_b,
  output logic              period_start
);
  localparam int CNT_W = $clog2(PERIOD);
  localparam int NCTL  = 2;

  logic [CNT_W-1:0]  ramp;
  logic              at_end;
  logic [WORD_W-1:0] words_in  [NCTL];
  logic [WORD_W-1:0] words_q   [NCTL];

  assign words_in[0] = err_lvl;
  assign words_in[1] = dt_lvl;

  pwm_ramp #(.PERIOD(PERIOD)) u_ramp (
    .clk      (clk),
    .rst      (rst),
    .ramp     (ramp),
    .at_start (period_start),
    .at_end   (at_end)
  );

  pwm_word_latch #(.WORD_W(WORD_W), .NUM(NCTL)) u_words (
    .clk     (clk),
    .rst     (rst),
    .capture (period_start),
    .din     (words_in),
    .dout    (words_q)
  );

  pwm_steer #(.WORD_W(WORD_W), .CNT_W(CNT_W), .DT_OFS(DT_OFS)) u_steer (
    .clk     (clk),
    .rst     (rst),
    .ramp    (ramp),
    .at_end  (at_end),
    .inhibit (inhibit),
    .err_q   (words_q[0]),
    .dt_q    (words_q[1]),
    .drv_a   (drv_a),
    .drv_b   (drv_b)
  );

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(drv_a && drv_b));
  // R5
  restart_off_chk: assert property (@(posedge clk) disable iff (rst)
    period_start |-> (!drv_a && !drv_b));
  // R9
  inhibit_off_chk: assert property (@(posedge clk) disable iff (rst)
    inhibit |-> (!drv_a && !drv_b));
  // R1
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    period_start |=> !period_start);
endmodule

// File: tb/pushpull_pwm_test.sv
module pushpull_pwm_test;
  localparam int PERIOD = 169;
  localparam int DT_OFS = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] err_lvl = '0;
  logic [7:0] dt_lvl  = '0;
  logic inhibit = 1'b0;
  logic drv_a, drv_b, period_start;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  pushpull_pwm uut (
    .clk(clk), .rst(rst), .err_lvl(err_lvl), .dt_lvl(dt_lvl),
    .inhibit(inhibit), .drv_a(drv_a), .drv_b(drv_b),
    .period_start(period_start)
  );

  function automatic int exp_width(input int e, input int d);
    int t = (e > d + DT_OFS) ? e : d + DT_OFS;
    return (PERIOD - 1 - t > 0) ? PERIOD - 1 - t : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_start();
    @(negedge clk);
    while (!period_start) @(negedge clk);
  endtask

  // Counts high cycles of each drive over one period, starting at a strobe.
  task automatic measure(input bit aligned, input int chg_at, input int chg_err,
                         output int ca, output int cb);
    if (!aligned) wait_start();
    ca = 0; cb = 0;
    for (int i = 0; i < PERIOD; i++) begin
      if (i > 0) @(negedge clk);
      if (i == chg_at) err_lvl = 8'(chg_err);
      ca += int'(drv_a);
      cb += int'(drv_b);
    end
  endtask

  task automatic width_case(input string req, input int e, input int d);
    int ca, cb, w;
    err_lvl = 8'(e); dt_lvl = 8'(d);
    measure(0, -1, 0, ca, cb);
    w = exp_width(e, d);
    chk((ca + cb) == w && (ca == 0 || cb == 0), req, ca + cb, w);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    // R11: held reset
    chk(!drv_a && !drv_b, "R11 drives low in reset", int'(drv_a) + int'(drv_b), 0);
    chk(period_start, "R11 ramp at zero in reset", int'(period_start), 1);
    rst = 1'b0;
  endtask

  task automatic t_first_and_alternate();
    int ca, cb, ca2, cb2;
    // R11 R6: first period after reset goes to A, the next to B
    measure(1, -1, 0, ca, cb);
    chk(ca == exp_width(0, 0) && cb == 0, "R11 first pulse on A", ca, exp_width(0, 0));
    measure(0, -1, 0, ca2, cb2);
    chk(cb2 == exp_width(0, 0) && ca2 == 0, "R6 second pulse on B", cb2, exp_width(0, 0));
    // R7: minimum dead time and duty band (per mille of two periods)
    chk(ca == PERIOD - 1 - DT_OFS, "R7 zero-word width", ca, PERIOD - 1 - DT_OFS);
    chk(ca * 1000 / (2 * PERIOD) >= 450 && ca * 1000 / (2 * PERIOD) < 500,
        "R7 duty band", ca * 1000 / (2 * PERIOD), 479);
  endtask

  task automatic t_strobe();
    int n = 0;
    wait_start();
    @(negedge clk);
    n = 1;
    while (!period_start) begin
      @(negedge clk);
      n++;
    end
    chk(n == PERIOD, "R1 strobe spacing", n, PERIOD);
  endtask

  task automatic t_widths();
    width_case("R2 error word 100", 100, 0);
    width_case("R2 dead-time word 50", 0, 50);
    width_case("R3 dead-time governs", 40, 80);
    width_case("R3 error governs", 80, 40);
    width_case("R3 smaller word moved", 80, 10);
    width_case("R8 dead-time at zero-duty limit", 0, PERIOD - 1 - DT_OFS);
    width_case("R8 dead-time just below limit", 0, PERIOD - 2 - DT_OFS);
    width_case("R8 error word past ramp top", 200, 0);
  endtask

  task automatic t_linear();
    int a1, b1, a2, b2;
    err_lvl = 8'd110; dt_lvl = 8'd0;
    measure(0, -1, 0, a1, b1);
    err_lvl = 8'd120;
    measure(0, -1, 0, a2, b2);
    chk((a1 + b1) - (a2 + b2) == 10, "R4 error step of 10", (a1 + b1) - (a2 + b2), 10);
    err_lvl = 8'd0; dt_lvl = 8'd30;
    measure(0, -1, 0, a1, b1);
    dt_lvl = 8'd37;
    measure(0, -1, 0, a2, b2);
    chk((a1 + b1) - (a2 + b2) == 7, "R4 dead-time step of 7", (a1 + b1) - (a2 + b2), 7);
  endtask

  task automatic t_midchange();
    int a1, b1, a2, b2;
    err_lvl = 8'd0; dt_lvl = 8'd0;
    // R10: change error word at ramp 80; this period keeps the old width
    measure(0, 80, 150, a1, b1);
    chk(a1 + b1 == exp_width(0, 0), "R10 width kept within period", a1 + b1, exp_width(0, 0));
    measure(0, -1, 0, a2, b2);
    chk(a2 + b2 == exp_width(150, 0), "R10 new width next period", a2 + b2, exp_width(150, 0));
  endtask

  task automatic t_inhibit();
    int ca, cb;
    err_lvl = 8'd0; dt_lvl = 8'd0;
    wait_start();
    repeat (50) @(negedge clk);
    chk(drv_a || drv_b, "R9 pulse active before inhibit", int'(drv_a) + int'(drv_b), 1);
    inhibit = 1'b1;
    #1;
    // R9: same-cycle shutoff
    chk(!drv_a && !drv_b, "R9 immediate off", int'(drv_a) + int'(drv_b), 0);
    repeat (PERIOD + 20) begin
      @(negedge clk);
      if (drv_a || drv_b) chk(0, "R9 held off", 1, 0);
    end
    wait_start();
    inhibit = 1'b0;
    measure(1, -1, 0, ca, cb);
    chk(ca == exp_width(0, 0) && cb == 0, "R9 R6 first pulse after release on A", ca, exp_width(0, 0));
    measure(0, -1, 0, ca, cb);
    chk(cb == exp_width(0, 0) && ca == 0, "R6 then B", cb, exp_width(0, 0));
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_first_and_alternate();
    t_strobe();
    t_widths();
    t_linear();
    t_midchange();
    t_inhibit();
    done = 1;
    finish_run();
  end
endmodule